// File: doc/BRIEF.md
# Flag-Updating Integer ALU

This block is a single-cycle integer ALU for 8-, 16- or 32-bit operands. It keeps a persistent six-bit status register. On every cycle with `valid` high it takes an operation code, an operand width, a destination value and a source value. It produces the result and a write strobe for that result without waiting for a clock edge. On the following clock edge it updates only those status bits that the selected operation is defined to change.

The result and `res_we` are combinational from the inputs and the current flags. The flags are registered. An upstream controller drives one operation per cycle and writes `res` back to its destination when `res_we` is high. It reads `flags` to decide conditional branches. Carry-chained arithmetic (add-with-carry, subtract-with-borrow) takes the carry from the flag register left by the previous operation.

Flag bit positions in `flags`: bit 0 carry (CF), bit 1 parity (PF), bit 2 auxiliary carry (AF), bit 3 zero (ZF), bit 4 sign (SF), bit 5 overflow (OF).

Operation codes on `op`: 0 move, 1 invert, 2 negate, 3 and, 4 or, 5 increment, 6 decrement, 7 add, 8 add-with-carry, 9 subtract, 10 subtract-with-borrow, 11 compare. Codes 12 to 15 are unused. Width codes on `size`: 0 = 8 bit, 1 = 16 bit, 2 or 3 = 32 bit.

Top module: `flag_alu`

## Requirements
- R1: A synchronous reset clears all six flags to 0. While `valid` is low, `res_we` is 0 and the flags hold their value.
- R2: Move (op 0) returns the source and invert (op 1) returns the bitwise inverse of the destination. Both assert `res_we` and leave every flag unchanged.
- R3: Negate (op 2) returns 0 minus the source. CF becomes 1 exactly when the width-truncated source is nonzero. OF, SF, ZF, AF and PF follow the subtraction 0 − source.
- R4: And (op 3) and or (op 4) return the bitwise result. They clear OF and CF, set SF, ZF and PF from the result, and hold AF unchanged.
- R5: Increment (op 5) and decrement (op 6) add or subtract 1. CF is held. OF, SF, ZF, AF and PF follow the result.
- R6: Add (op 7) and add-with-carry (op 8) update all six flags. Add-with-carry adds the current CF as carry-in. CF is the unsigned carry out of the selected width. OF is set when both operands share a sign and the result sign differs from it.
- R7: Subtract (op 9) and subtract-with-borrow (op 10) update all six flags. Subtract-with-borrow also subtracts the current CF. CF is the unsigned borrow. OF is set when the operand signs differ and the result sign differs from the destination sign.
- R8: Compare (op 11) updates the flags exactly as subtract does and keeps `res_we` at 0.
- R9: Operands are truncated to the width selected by `size`. SF, ZF, CF and OF are judged at that width. Result bits above that width are 0.
- R10: AF is the carry (or borrow) out of bit 3. PF is 1 when bits 7..0 of the result hold an even number of ones.
- R11: Unused codes 12 to 15 keep `res_we` at 0 and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Operation strobe for this cycle |
| op | input | 4 | Operation code |
| size | input | 2 | Operand width code |
| dst | input | 32 | Destination operand |
| src | input | 32 | Source operand |
| res | output | 32 | Result, zero above the selected width |
| res_we | output | 1 | Result write enable |
| flags | output | 6 | Status flags {OF,SF,ZF,AF,PF,CF} |

## Verification
The bench aims at carries and overflows at the 8- and 16-bit boundaries, where a design that takes carry or sign from bit 31 would report wrong CF or OF for narrow operands. Chained add-with-carry and subtract-with-borrow runs expose a design that ignores the stored carry, or that consumes the carry of the current cycle. Negate of zero and of the most negative value checks the special CF rule and the one overflowing case. Interleaved logic and increment/decrement operations catch a design that clobbers AF or CF when it must hold them, and compare catches a result write that leaks.

// File: rtl/flag_alu.sv
module flag_alu (
  input  logic        clk,
  input  logic        rst,
  input  logic        valid,
  input  logic [3:0]  op,
  input  logic [1:0]  size,
  input  logic [31:0] dst,
  input  logic [31:0] src,
  output logic [31:0] res,
  output logic        res_we,
  output logic [5:0]  flags
);

  localparam logic [3:0] OP_MOV = 4'd0,  OP_NOT = 4'd1,  OP_NEG = 4'd2,  OP_AND = 4'd3;
  localparam logic [3:0] OP_OR  = 4'd4,  OP_INC = 4'd5,  OP_DEC = 4'd6,  OP_ADD = 4'd7;
  localparam logic [3:0] OP_ADC = 4'd8,  OP_SUB = 4'd9,  OP_SBB = 4'd10, OP_CMP = 4'd11;
  localparam int CF = 0, PF = 1, AF = 2, ZF = 3, SF = 4, OF = 5;

  logic [31:0] mask, a, b, r;
  logic        cin, is_sub;
  logic [32:0] sum;
  logic        sa, sb, sr, carry, ovf, zf, sf, pf, af;
  logic [5:0]  nf;

  function automatic logic top_bit(input logic [1:0] sz, input logic [31:0] v);
    case (sz)
      2'd0:    return v[7];
      2'd1:    return v[15];
      default: return v[31];
    endcase
  endfunction

  always_comb
    case (size)
      2'd0:    mask = 32'h0000_00FF;
      2'd1:    mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase

  always_comb begin
    a = dst & mask;
    b = src & mask;
    cin = 1'b0;
    is_sub = 1'b0;
    case (op)
      OP_NEG: begin a = '0; is_sub = 1'b1; end
      OP_INC: b = 32'd1;
      OP_DEC: begin b = 32'd1; is_sub = 1'b1; end
      OP_ADC: cin = flags[CF];
      OP_SUB, OP_CMP: is_sub = 1'b1;
      OP_SBB: begin is_sub = 1'b1; cin = flags[CF]; end
      default: ;
    endcase
  end

  assign sum = is_sub ? ({1'b0, a} - {1'b0, b} - {32'd0, cin})
                      : ({1'b0, a} + {1'b0, b} + {32'd0, cin});

  always_comb begin
    case (op)
      OP_MOV:  r = src;
      OP_NOT:  r = ~dst;
      OP_AND:  r = dst & src;
      OP_OR:   r = dst | src;
      default: r = sum[31:0];
    endcase
    r = r & mask;
  end

  assign sa = top_bit(size, a);
  assign sb = top_bit(size, b);
  assign sr = top_bit(size, r);
  assign carry = is_sub ? sum[32] : (size == 2'd0 ? sum[8] : size == 2'd1 ? sum[16] : sum[32]);
  assign ovf = is_sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
  assign af = a[4] ^ b[4] ^ sum[4];
  assign zf = (r == '0);
  assign sf = sr;
  assign pf = ~^r[7:0];

  always_comb
    case (op)
      OP_NEG:                         nf = {ovf, sf, zf, af, pf, (b != '0)};
      OP_AND, OP_OR:                  nf = {1'b0, sf, zf, flags[AF], pf, 1'b0};
      OP_INC, OP_DEC:                 nf = {ovf, sf, zf, af, pf, flags[CF]};
      OP_ADD, OP_ADC, OP_SUB,
      OP_SBB, OP_CMP:                 nf = {ovf, sf, zf, af, pf, carry};
      default:                        nf = flags;
    endcase

  assign res    = r;
  assign res_we = valid && (op <= OP_SBB);

  always_ff @(posedge clk)
    if (rst) flags <= '0;
    else if (valid) flags <= nf;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> flags == 6'd0);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> flags == $past(flags));
  // R2
  move_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && (op == OP_MOV || op == OP_NOT)) |=> flags == $past(flags));
  // R4
  logic_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && (op == OP_AND || op == OP_OR)) |=>
      (!flags[OF] && !flags[CF] && flags[AF] == $past(flags[AF])));
  // R5
  step_keeps_cf_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && (op == OP_INC || op == OP_DEC)) |=> flags[CF] == $past(flags[CF]));
  // R8
  compare_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |-> !res_we);
  // R9
  narrow_result_chk: assert property (@(posedge clk) disable iff (rst)
    (size == 2'd0) |-> res[31:8] == 24'd0);
  // R11
  unused_op_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && op >= 4'd12) |=> (flags == $past(flags)));

endmodule

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1, valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] dst = '0, src = '0;
  logic [31:0] res;
  logic        res_we;
  logic [5:0]  flags;

  int checks = 0, errors = 0;
  logic [5:0] exp_fl = '0;

  flag_alu u0 (.clk(clk), .rst(rst), .valid(valid), .op(op), .size(size),
               .dst(dst), .src(src), .res(res), .res_we(res_we), .flags(flags));

  always #(CLK_P/2) clk = ~clk;

  function automatic string tag(input logic v, input logic [3:0] o);
    if (!v) return "R1";
    case (o)
      0, 1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5, 6: return "R5";
      7, 8: return "R6";
      9, 10: return "R7";
      11: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] o, input logic [1:0] sz,
      input logic [31:0] d, input logic [31:0] s, input logic [5:0] fl,
      output logic we, output logic [31:0] rv, output logic [5:0] nfl);
    int n;
    longint m, half, x, y, ci, full, sfull, r;
    logic sub, cf, of, af, arith;
    n = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m = (longint'(1) << n) - 1;
    half = longint'(1) << (n - 1);
    x = longint'(d) & m;
    y = longint'(s) & m;
    ci = 0; sub = 0; arith = 1; r = 0;
    we = (o <= 10);
    nfl = fl;
    case (o)
      0: begin r = y; arith = 0; end
      1: begin r = (~longint'(d)) & m; arith = 0; end
      2: begin x = 0; sub = 1; end
      3: begin r = x & y; arith = 0; end
      4: begin r = x | y; arith = 0; end
      5: y = 1;
      6: begin y = 1; sub = 1; end
      7: ;
      8: ci = fl[0];
      9, 11: sub = 1;
      10: begin sub = 1; ci = fl[0]; end
      default: arith = 0;
    endcase
    if (arith) begin
      full  = sub ? x - y - ci : x + y + ci;
      sfull = sub ? ((x >= half) ? x - (m + 1) : x) - ((y >= half) ? y - (m + 1) : y) - ci
                  : ((x >= half) ? x - (m + 1) : x) + ((y >= half) ? y - (m + 1) : y) + ci;
      r  = full & m;
      cf = sub ? (full < 0) : (full > m);
      of = (sfull >= half) || (sfull < -half);
      af = sub ? (((x & 15) - (y & 15) - ci) < 0) : (((x & 15) + (y & 15) + ci) > 15);
    end else begin
      cf = 0; of = 0; af = 0;
    end
    rv = 32'(r);
    if (o <= 11 && !(o <= 1)) begin
      nfl[3] = (r == 0);
      nfl[4] = (r >= half);
      nfl[1] = ($countones(rv[7:0]) % 2) == 0;
      if (o == 3 || o == 4) begin
        nfl[5] = 0; nfl[0] = 0;
      end else begin
        nfl[5] = of; nfl[2] = af;
        if (o == 2) nfl[0] = (y != 0);
        else if (o != 5 && o != 6) nfl[0] = cf;
      end
    end
  endfunction

  task automatic run(input logic v, input logic [3:0] o, input logic [1:0] sz,
                     input logic [31:0] d, input logic [31:0] s);
    logic we_e; logic [31:0] r_e; logic [5:0] f_e;
    string req;
    @(negedge clk);
    valid = v; op = o; size = sz; dst = d; src = s;
    model(o, sz, d, s, exp_fl, we_e, r_e, f_e);
    if (!v) begin we_e = 0; f_e = exp_fl; end
    req = tag(v, o);
    #1;
    chk(req, "res_we", res_we, we_e);
    if (we_e) chk(sz != 2 ? "R9" : req, "res", res, r_e);
    @(posedge clk); #1;
    chk(req, "flags", flags, f_e);
    exp_fl = f_e;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_0080;
      3: return 32'h0000_7FFF;
      4: return 32'h8000_0000;
      5: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 chk("R1", "reset flags", flags, 0);
    @(negedge clk) rst = 0;
    // R6 / R9 / R10: 8-bit carry, zero, AF, PF from 0xFF+1
    run(1, 7, 0, 32'h0000_01FF, 32'h1);
    // R6: chained add-with-carry consumes CF
    run(1, 8, 0, 32'h0, 32'h0);
    // R6 / R9: 16-bit signed overflow
    run(1, 7, 1, 32'h7FFF, 32'h1);
    // R7: borrow chain
    run(1, 9, 2, 32'h0, 32'h1);
    run(1, 10, 2, 32'h5, 32'h2);
    // R3: negate zero and most negative byte
    run(1, 2, 0, 32'h0, 32'h0);
    run(1, 2, 0, 32'h0, 32'h80);
    // R4: AF held while OF/CF clear
    run(1, 7, 0, 32'h0F, 32'h01);
    run(1, 3, 0, 32'hF0, 32'h0F);
    // R5: CF held across increment
    run(1, 9, 0, 32'h0, 32'h1);
    run(1, 5, 0, 32'h7F, 32'h0);
    run(1, 6, 1, 32'h0, 32'h0);
    // R8: compare equal values
    run(1, 11, 2, 32'h1234_5678, 32'h1234_5678);
    // R2: move and invert
    run(1, 0, 1, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    run(1, 1, 0, 32'h0000_00A5, 32'h0);
    // R11 and R1: unused code and idle cycle
    run(1, 13, 2, 32'h1, 32'h1);
    run(0, 7, 2, 32'hFFFF_FFFF, 32'h1);
    for (int i = 0; i < 3000; i++)
      run(($urandom % 10) != 0, 4'($urandom % 16), 2'($urandom % 4), pick(), pick());
    // R1: reset mid-run
    @(negedge clk) rst = 1; valid = 0;
    @(posedge clk); #1;
    chk("R1", "mid-run reset flags", flags, 0);
    exp_fl = '0;
    @(negedge clk) rst = 0;
    run(1, 9, 0, 32'h10, 32'h20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule